// File: doc/BRIEF.md
# Word Copy DMA Engine

This block copies a run of 32-bit words from one memory address to another. Software programs it through a small byte-addressed register window. It first sets a source address and a destination address. It then writes a word count, and that write starts the copy. The engine walks the run one word at a time over a request/acknowledge master port. For each word it does one read and then one write. If configured to do so, it reverses the byte order of each word on the way through.

When the run is finished, the engine can raise a level interrupt. Software clears it by writing a one to an acknowledge byte. A command/result mailbox is also provided. A command word can load a fixed identification constant into the result register, or it can load a snapshot of one internal register. The result register is then read back at its own offset.

Reads of the register window are combinational from the address. Writes take effect at the clock edge where `reg_valid_i` and `reg_write_i` are both high.

Top module: `word_dma`

## Requirements
- R1: After reset, the source, destination, count, config, status and result registers all read zero, `irq_o` is low and no memory request is issued.
- R2: While idle, a write to offset 0x00 sets the source address and a write to offset 0x04 sets the destination address. Both read back at the same offsets, and offset 0x08 reads back the remaining word count.
- R3: A write to offset 0x08 while idle loads the count and starts a copy. Busy (status bit 7, byte 0 of the word at 0x0C) reads 1 from the cycle after that write until the count reaches zero. Writes to 0x00, 0x04 or 0x08 while busy are ignored.
- R4: Each word is read from the source address with `mem_we_o` low and then written to the destination address with `mem_we_o` high. Each request is held stable until `mem_ack_i`. After each write both addresses advance by 4 and the count drops by 1.
- R5: When config bit 7 is 1, each written word is the read word with its bytes reversed (bits 7:0 swap with 31:24, and 15:8 swap with 23:16). When config bit 7 is 0, words are copied unchanged. Config is byte 2 of the word at 0x0C and is written with byte enable 2.
- R6: At completion, status bit 0 (pending) sets and `irq_o` goes high only if config bit 0 is 1 at that moment. If config bit 0 is 0, pending stays 0.
- R7: A write with byte enable 1 at word 0x0C whose data bit 8 is 1 clears pending and `irq_o`. The same write with bit 8 at 0 has no effect. A completion in the same cycle wins over the clear.
- R8: A count of zero issues no memory request. Busy stays high for exactly one cycle, and pending is still set if config bit 0 is 1.
- R9: A write to offset 0x10 with bit 29 set loads the result register with 0x16C311DB, whether or not bit 31 is also set.
- R10: A write to 0x10 with bit 29 clear and bit 31 set loads the result register with the internal register selected by data[5:0]: 0 gives the status byte, 1 the source, 2 the destination, 3 the count, 4 the config byte, and any other value gives all ones. With both bits clear, the result is unchanged.
- R11: Offset 0x14 reads the result register. A write to 0x14 sets it to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | Access is a write |
| reg_addr_i | input | 5 | Byte offset of the register word |
| reg_be_i | input | 4 | Byte enables for the word at 0x0C |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Master request |
| mem_we_o | output | 1 | Master request is a write |
| mem_addr_o | output | 32 | Master byte address |
| mem_wdata_o | output | 32 | Master write data |
| mem_rdata_i | input | 32 | Master read data, valid with ack |
| mem_ack_i | input | 1 | Master request accepted |
| irq_o | output | 1 | Completion interrupt level |

## Verification
The embedded assertions check the per-cycle protocol rules on every cycle:
- busy rises after a start;
- requests and addresses hold until acknowledge;
- addresses advance by 4 and the count drops by 1 on each write acknowledge;
- no request is issued while idle;
- pending rises only after an enabled completion;
- the acknowledge byte clears pending;
- the ID command loads the constant.

Only the bench scenarios can show the end-to-end effects. These are the destination memory contents, including byte reversal, words just past the run left untouched, writes ignored while busy, the one-cycle busy of a zero-length run, and the register-select mapping of the mailbox. Randomized runs use varying lengths, addresses, acknowledge latencies and swap settings.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  localparam logic [4:0] OFS_SRC = 5'h00;
  localparam logic [4:0] OFS_DST = 5'h04;
  localparam logic [4:0] OFS_LEN = 5'h08;
  localparam logic [4:0] OFS_CTL = 5'h0C;
  localparam logic [4:0] OFS_CMD = 5'h10;
  localparam logic [4:0] OFS_RES = 5'h14;

  localparam logic [31:0] ID_WORD = 32'h16C3_11DB;

  localparam int unsigned CMD_ID_BIT  = 29;
  localparam int unsigned CMD_SEL_BIT = 31;
  localparam int unsigned CFG_SWAP    = 7;
  localparam int unsigned CFG_IRQ_EN  = 0;
  localparam int unsigned ACK_BIT     = 8;

  typedef enum logic [1:0] {
    MV_IDLE,
    MV_CHECK,
    MV_READ,
    MV_WRITE
  } mv_state_e;
endpackage

// File: rtl/wdma_swap.sv
module wdma_swap #(
  parameter int unsigned DW = 32
) (
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  localparam int unsigned NB = DW / 8;

  logic [DW-1:0] rev;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign rev[8*i +: 8] = data_i[8*(NB-1-i) +: 8];
  end

  assign data_o = en_i ? rev : data_i;
endmodule

// File: rtl/wdma_mover.sv
module wdma_mover
  import wdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          src_we_i,
  input  logic          dst_we_i,
  input  logic          len_we_i,
  input  logic [31:0]   wdata_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] rbuf_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  mv_state_e     state_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MV_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      rbuf_q  <= '0;
    end else begin
      unique case (state_q)
        MV_IDLE: begin
          if (src_we_i) src_q <= wdata_i[AW-1:0];
          if (dst_we_i) dst_q <= wdata_i[AW-1:0];
          if (len_we_i) begin
            cnt_q   <= wdata_i[CW-1:0];
            state_q <= MV_CHECK;
          end
        end
        MV_CHECK: state_q <= (cnt_q == '0) ? MV_IDLE : MV_READ;
        MV_READ: begin
          if (mem_ack_i) begin
            rbuf_q  <= mem_rdata_i;
            state_q <= MV_WRITE;
          end
        end
        MV_WRITE: begin
          if (mem_ack_i) begin
            src_q   <= src_q + STEP;
            dst_q   <= dst_q + STEP;
            cnt_q   <= cnt_q - 1'b1;
            state_q <= MV_CHECK;
          end
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != MV_IDLE);
  assign done_o     = (state_q == MV_CHECK) && (cnt_q == '0);
  assign mem_req_o  = (state_q == MV_READ) || (state_q == MV_WRITE);
  assign mem_we_o   = (state_q == MV_WRITE);
  assign mem_addr_o = (state_q == MV_WRITE) ? dst_q : src_q;
  assign src_o      = src_q;
  assign dst_o      = dst_q;
  assign cnt_o      = cnt_q;
  assign rbuf_o     = rbuf_q;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && len_we_i) |=> busy_o); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=>
      (src_o == $past(src_o) + STEP && dst_o == $past(dst_o) + STEP && cnt_o == $past(cnt_o) - 1'b1)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R8
endmodule

// File: rtl/wdma_regs.sv
module wdma_regs
  import wdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_valid_i,
  input  logic          reg_write_i,
  input  logic [4:0]    reg_addr_i,
  input  logic [3:0]    reg_be_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  output logic          src_we_o,
  output logic          dst_we_o,
  output logic          len_we_o,
  output logic [7:0]    cfg_o,
  output logic          pending_o
);
  logic        wr;
  logic        ack_wr;
  logic [7:0]  cfg_q;
  logic        pend_q;
  logic [31:0] res_q;
  logic [7:0]  stat;
  logic [31:0] sel_word;

  assign wr       = reg_valid_i && reg_write_i;
  assign src_we_o = wr && (reg_addr_i == OFS_SRC);
  assign dst_we_o = wr && (reg_addr_i == OFS_DST);
  assign len_we_o = wr && (reg_addr_i == OFS_LEN);
  assign ack_wr   = wr && (reg_addr_i == OFS_CTL) && reg_be_i[1] && reg_wdata_i[ACK_BIT];
  assign stat     = {busy_i, 6'b0, pend_q};

  always_comb begin
    unique case (reg_wdata_i[5:0])
      6'd0:    sel_word = {24'b0, stat};
      6'd1:    sel_word = 32'(src_i);
      6'd2:    sel_word = 32'(dst_i);
      6'd3:    sel_word = 32'(cnt_i);
      6'd4:    sel_word = {24'b0, cfg_q};
      default: sel_word = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
      res_q  <= '0;
    end else begin
      if (wr && reg_addr_i == OFS_CTL && reg_be_i[2]) cfg_q <= reg_wdata_i[23:16];
      // completion wins over a same-cycle acknowledge
      if (done_i && cfg_q[CFG_IRQ_EN]) pend_q <= 1'b1;
      else if (ack_wr)                 pend_q <= 1'b0;
      if (wr && reg_addr_i == OFS_CMD) begin
        if (reg_wdata_i[CMD_ID_BIT])       res_q <= ID_WORD;
        else if (reg_wdata_i[CMD_SEL_BIT]) res_q <= sel_word;
      end else if (wr && reg_addr_i == OFS_RES) begin
        res_q <= '1;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_SRC: reg_rdata_o = 32'(src_i);
      OFS_DST: reg_rdata_o = 32'(dst_i);
      OFS_LEN: reg_rdata_o = 32'(cnt_i);
      OFS_CTL: reg_rdata_o = {8'b0, cfg_q, 8'b0, stat};
      OFS_RES: reg_rdata_o = res_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign pending_o = pend_q;

  AST_PEND_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(done_i && cfg_q[CFG_IRQ_EN])); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !done_i) |=> !pend_q); // R7
  AST_ID_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_addr_i == OFS_CMD && reg_wdata_i[CMD_ID_BIT]) |=> (res_q == ID_WORD)); // R9
  AST_RES_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_addr_i == OFS_RES) |=> (res_q == '1)); // R11
endmodule

// File: rtl/word_dma.sv
module word_dma
  import wdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_valid_i,
  input  logic          reg_write_i,
  input  logic [4:0]    reg_addr_i,
  input  logic [3:0]    reg_be_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          irq_o
);
  logic          src_we, dst_we, len_we;
  logic          busy, done;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rbuf;
  logic [7:0]    cfg;
  logic          pending;

  wdma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_be_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .done_i(done), .src_i(src), .dst_i(dst), .cnt_i(cnt),
    .src_we_o(src_we), .dst_we_o(dst_we), .len_we_o(len_we),
    .cfg_o(cfg), .pending_o(pending)
  );

  wdma_mover #(.AW(AW), .CW(CW), .DW(DW)) u_mover (
    .clk_i, .rst_ni,
    .src_we_i(src_we), .dst_we_i(dst_we), .len_we_i(len_we), .wdata_i(reg_wdata_i),
    .src_o(src), .dst_o(dst), .cnt_o(cnt), .busy_o(busy), .done_o(done),
    .mem_req_o, .mem_we_o, .mem_addr_o, .rbuf_o(rbuf),
    .mem_rdata_i, .mem_ack_i
  );

  wdma_swap #(.DW(DW)) u_swap (
    .en_i(cfg[CFG_SWAP]), .data_i(rbuf), .data_o(mem_wdata_o)
  );

  assign irq_o = pending;
endmodule

// File: tb/sim_word_dma.sv
module sim_word_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0, req_cycles = 0, dly = 0;
  bit finished = 0;
  logic [31:0] mem [256];
  logic        ack_r = 1'b0;
  logic [31:0] rdat = '0;

  always #10 clk = ~clk;

  word_dma u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_addr_i(reg_addr),
    .reg_be_i(reg_be), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .irq_o(irq)
  );

  assign mem_ack   = ack_r;
  assign mem_rdata = rdat;

  // memory model with 0..2 cycle acknowledge latency
  always @(posedge clk) begin
    if (mem_req) req_cycles++;
    if (ack_r) ack_r <= 1'b0;
    else if (mem_req) begin
      if (dly == 0) begin
        ack_r <= 1'b1;
        rdat  <= mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        dly <= int'($urandom % 3);
      end else dly <= dly - 1;
    end
  end

  function automatic logic [31:0] rev32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(posedge clk); #1;
    reg_valid = 1'b0; reg_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(5'h0C, s);
      if (!s[7]) return;
      @(negedge clk);
    end
    chk("R3 timeout", 32'd1, 32'd0);
  endtask

  // copy with expected destination computed before start
  task automatic run_copy(input int si, input int di, input int len, input bit swap, input bit ien);
    logic [31:0] exp [8];
    logic [31:0] after, s;
    for (int k = 0; k < len; k++) exp[k] = swap ? rev32(mem[si+k]) : mem[si+k];
    after = mem[di+len];
    wr(5'h0C, {8'b0, swap, 6'b0, ien, 16'b0}, 4'b0100);
    wr(5'h00, si*4, 4'hF);
    wr(5'h04, di*4, 4'hF);
    wr(5'h08, len, 4'hF);
    wait_idle();
    for (int k = 0; k < len; k++) chk(swap ? "R5 swapped word" : "R4 copied word", mem[di+k], exp[k]);
    chk("R4 word past run untouched", mem[di+len], after);
    rd(5'h00, s); chk("R4 source advanced", s, (si+len)*4);
    rd(5'h04, s); chk("R4 dest advanced", s, (di+len)*4);
    rd(5'h08, s); chk("R4 count zero", s, 0);
    rd(5'h0C, s); chk("R6 pending", {31'b0, s[0]}, {31'b0, ien});
    chk("R6 irq", {31'b0, irq}, {31'b0, ien});
    wr(5'h0C, 32'h100, 4'b0010);
  endtask

  initial begin
    logic [31:0] s;
    int rc;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, s); chk("R1 src", s, 0);
    rd(5'h04, s); chk("R1 dst", s, 0);
    rd(5'h08, s); chk("R1 cnt", s, 0);
    rd(5'h0C, s); chk("R1 ctl", s, 0);
    rd(5'h14, s); chk("R1 result", s, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 no requests", req_cycles, 0);

    // R2 readback
    wr(5'h00, 32'h0000_0040, 4'hF);
    wr(5'h04, 32'h0000_0280, 4'hF);
    rd(5'h00, s); chk("R2 src", s, 32'h40);
    rd(5'h04, s); chk("R2 dst", s, 32'h280);
    wr(5'h0C, 32'h0081_0000, 4'b0100);
    rd(5'h0C, s); chk("R5 cfg readback", s[23:16], 8'h81);

    // R3 busy timing and ignored writes while busy
    wr(5'h0C, 32'h0001_0000, 4'b0100);
    wr(5'h00, 32'h0, 4'hF);
    wr(5'h04, 32'h200, 4'hF);
    s = mem[128+4];
    wr(5'h08, 32'd4, 4'hF);
    rd(5'h0C, s); chk("R3 busy after start", s[7], 1'b1);
    wr(5'h08, 32'd9, 4'hF);
    wr(5'h00, 32'h80, 4'hF);
    wait_idle();
    rd(5'h00, s); chk("R3 src write ignored while busy", s, 32'h10);
    rd(5'h08, s); chk("R3 length write ignored while busy", s, 0);
    rd(5'h0C, s); chk("R6 pending set", s[0], 1'b1);
    chk("R6 irq high", irq, 1'b1);

    // R7 acknowledge
    wr(5'h0C, 32'h0000_0000, 4'b0010);
    rd(5'h0C, s); chk("R7 ack bit clear no effect", s[0], 1'b1);
    wr(5'h0C, 32'h0000_0100, 4'b0010);
    rd(5'h0C, s); chk("R7 ack clears pending", s[0], 1'b0);
    chk("R7 irq low", irq, 1'b0);

    // R5 directed swap, interrupt off
    run_copy(10, 150, 3, 1'b1, 1'b0);

    // R8 zero length
    wr(5'h0C, 32'h0001_0000, 4'b0100);
    rc = req_cycles;
    wr(5'h08, 32'd0, 4'hF);
    rd(5'h0C, s); chk("R8 busy first cycle", s[7], 1'b1);
    @(negedge clk);
    rd(5'h0C, s); chk("R8 busy one cycle", s[7], 1'b0);
    chk("R8 pending on zero length", s[0], 1'b1);
    chk("R8 no bus traffic", req_cycles, rc);
    wr(5'h0C, 32'h100, 4'b0010);

    // R9 R10 R11 mailbox
    wr(5'h00, 32'h0000_0124, 4'hF);
    wr(5'h10, 32'hA000_0001, 4'hF);
    rd(5'h14, s); chk("R9 id precedence", s, 32'h16C3_11DB);
    wr(5'h10, 32'h8000_0001, 4'hF);
    rd(5'h14, s); chk("R10 select source", s, 32'h124);
    wr(5'h10, 32'h8000_0004, 4'hF);
    rd(5'h14, s); chk("R10 select config", s, 32'h01);
    wr(5'h10, 32'h0000_0003, 4'hF);
    rd(5'h14, s); chk("R10 no command unchanged", s, 32'h01);
    wr(5'h10, 32'h8000_0009, 4'hF);
    rd(5'h14, s); chk("R10 unknown select", s, 32'hFFFF_FFFF);
    wr(5'h10, 32'h2000_0000, 4'hF);
    wr(5'h14, 32'h0, 4'hF);
    rd(5'h14, s); chk("R11 write sets all ones", s, 32'hFFFF_FFFF);

    // randomized runs
    for (int t = 0; t < 12; t++)
      run_copy(int'($urandom % 56), 128 + int'($urandom % 56), 1 + int'($urandom % 8),
               1'($urandom), 1'($urandom));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule